// File: doc/BRIEF.md
# Serial Port Control and Status Register Block

This block is the register front end of an asynchronous serial port. A processor reaches it through a simple word-addressed bus in a 256-byte window. Behind that window sit the line-setup, interrupt-enable, interrupt-flag, FIFO-control and bit-rate registers, together with a transmit queue and a receive queue of bytes. Software writes bytes into the transmit queue, where a line shifter drains them. The shifter pushes the bytes it receives into the receive queue, and software reads them out.

Every bus write replaces only the byte lanes it enables. The result is then cut down to the bits that the target register actually implements. Two status flags follow the queues. One says that received data is waiting and the other says that the transmit queue has room. Software clears a flag by writing zero to it. A single level interrupt is raised when an enabled flag is set. A FIFO-control write can flush either queue. Frames are fixed at eight data bits, no parity and one stop bit. There is no flow control and no DMA.

Top module: `uart_regblk`

## Requirements
- R1: After a synchronous reset, line control reads 0x40000000 and bit rate reads 0x03FF0000. Every other register reads 0, and both queues are empty: tx_avail is 0 and a read at 48 returns 0.
- R2: The register is selected by bus_addr[7:2] and bus_addr[1:0] are ignored. Byte offset 0 is line control, 4 line status, 8 interrupt control, 12 interrupt flags, 16 FIFO control, 20 bit rate, 32 transmit data and 48 receive data. Reads at any other offset, and at 32, return 0.
- R3: A write replaces only the byte lanes whose bus_be bit is set (be[n] covers bits 8n+7:8n). The register is then ANDed with its mask: line control 0xE17F0000, interrupt control 0x000F0000, FIFO control 0x001F0000, bit rate 0x03FF0000.
- R4: Line status has mask 0, so writes leave it at 0.
- R5: A write at 32 with bus_be[0] set pushes bus_wdata[7:0] into the 8-entry transmit queue. The push is dropped when the queue already holds 8 bytes, even if a pop happens in the same cycle.
- R6: tx_avail is 1 while the transmit queue is not empty, and tx_byte shows its oldest byte. tx_pop removes that byte; tx_pop on an empty queue has no effect.
- R7: rx_valid pushes rx_byte into the 8-entry receive queue unless the queue is full. A read at 48 returns the oldest byte and removes it. A read at 48 with the queue empty returns 0.
- R8: Interrupt flags occupy bits 18:16 (16 receive, 17 transmit, 18 error). At each edge a flag is set if its condition held before that edge: the receive queue is non-empty, or the transmit queue holds fewer than 8 bytes. Otherwise a write at 12 with bus_be[2] ANDs bits 18:16 with bus_wdata[18:16]. Setting wins over clearing.
- R9: irq is registered. It is 1 one cycle after (flag16 AND control bit 16) OR (flag17 AND control bit 17) holds. Control bits 18 and 19 do not drive irq.
- R10: A write at 16 with bus_be[2], bus_wdata[16] and bus_wdata[18] set empties the transmit queue on the next edge. With bits 16 and 17 set it empties the receive queue. If bit 16 is clear, no queue is emptied. The flush wins over a push in the same cycle.
- R11: bus_rdata is registered. It shows the read value from the edge where bus_rd was sampled and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address within the window |
| bus_be | input | 4 | Byte-lane enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| rx_valid | input | 1 | Received byte strobe from the shifter |
| rx_byte | input | 8 | Received byte |
| tx_pop | input | 1 | Shifter takes the transmit byte |
| tx_byte | output | 8 | Oldest transmit byte |
| tx_avail | output | 1 | Transmit queue not empty |
| irq | output | 1 | Level interrupt |

## Verification
The hardest situation to reach is a queue boundary that coincides with another event. Examples are a push into a full queue while a pop happens in the same cycle, a flush that lands on a push, and a flag clear while the flag's condition still holds. Directed sequences fill each queue past its depth and issue flushes and flag clears at those points. Long random runs then mix bus operations, receive strobes and transmit pops, so that these coincidences also occur many times in varied order. A cycle-accurate bench model checks every read, tx_byte, tx_avail and irq in each cycle.

// File: rtl/urb_pkg.sv
package urb_pkg;
  localparam int NCSR = 5;
  // plain registers: line ctl, line status, irq ctl, fifo ctl, bit rate
  localparam logic [31:0] CSR_MASK [NCSR] = '{32'hE17F0000, 32'h0, 32'h000F0000,
                                              32'h001F0000, 32'h03FF0000};
  localparam logic [31:0] CSR_RSTV [NCSR] = '{32'h40000000, 32'h0, 32'h0, 32'h0,
                                              32'h03FF0000};
  localparam logic [5:0]  CSR_WIDX [NCSR] = '{6'd0, 6'd1, 6'd2, 6'd4, 6'd5};
  localparam int CI_ICTL = 2;
  localparam logic [5:0] WIDX_FLAGS = 6'd3;
  localparam logic [5:0] WIDX_FCTL  = 6'd4;
  localparam logic [5:0] WIDX_TXD   = 6'd8;
  localparam logic [5:0] WIDX_RXD   = 6'd12;

  function automatic logic [31:0] lane_merge(input logic [31:0] old_v,
                                             input logic [31:0] new_v,
                                             input logic [3:0]  be);
    logic [31:0] r;
    r = old_v;
    for (int b = 0; b < 4; b++)
      if (be[b]) r[b*8 +: 8] = new_v[b*8 +: 8];
    return r;
  endfunction
endpackage

// File: rtl/urb_csr.sv
module urb_csr #(
  parameter logic [31:0] MASK = 32'h0,
  parameter logic [31:0] RSTV = 32'h0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        we,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  output logic [31:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= RSTV;
    else if (we) q <= urb_pkg::lane_merge(q, wdata, be) & MASK;
  end
endmodule

// File: rtl/urb_fifo.sv
module urb_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   count;
  logic          push_ok, pop_ok;

  assign empty   = (count == '0);
  assign full    = (count == (AW+1)'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rptr];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push_ok) wptr <= nxt(wptr);
      if (pop_ok)  rptr <= nxt(rptr);
      count <= count + (AW+1)'(push_ok) - (AW+1)'(pop_ok);
    end
  end

  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (rst)
    count <= (AW+1)'(DEPTH)); // R5
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop && !flush) |=> full); // R5
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    flush |=> empty); // R10
endmodule

// File: rtl/urb_flags.sv
module urb_flags (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr_we,
  input  logic [2:0] clr_keep,
  input  logic       rx_ne,
  input  logic       tx_nf,
  input  logic       rie,
  input  logic       tie,
  output logic [2:0] flags,
  output logic       irq
);
  logic [2:0] keep;
  assign keep = clr_we ? clr_keep : 3'b111;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      irq   <= 1'b0;
    end else begin
      flags <= (flags & keep) | {1'b0, tx_nf, rx_ne};
      irq   <= (flags[0] & rie) | (flags[1] & tie);
    end
  end

  AST_RX_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    rx_ne |=> flags[0]); // R8
  AST_TX_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    tx_nf |=> flags[1]); // R8
  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (rst)
    ((flags[0] && rie) || (flags[1] && tie)) |=> irq); // R9
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    !((flags[0] && rie) || (flags[1] && tie)) |=> !irq); // R9
endmodule

// File: rtl/uart_regblk.sv
module uart_regblk #(
  parameter int FIFO_DEPTH = 8,
  parameter int ADDR_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic              tx_pop,
  output logic [7:0]        tx_byte,
  output logic              tx_avail,
  output logic              irq
);
  import urb_pkg::*;
  localparam int IW = ADDR_W - 2;

  logic [IW-1:0] widx;
  logic [31:0]   csr_q [NCSR];
  logic [2:0]    flags;
  logic          tx_flush_q, rx_flush_q;
  logic          tx_empty, tx_full, rx_empty, rx_full;
  logic [7:0]    rx_dout;
  logic          fctl_wr, rx_rd;
  logic [31:0]   rd_mux;

  assign widx    = bus_addr[ADDR_W-1:2];
  assign fctl_wr = bus_wr && (widx == IW'(WIDX_FCTL)) && bus_be[2];
  assign rx_rd   = bus_rd && (widx == IW'(WIDX_RXD));

  for (genvar i = 0; i < NCSR; i++) begin : g_csr
    urb_csr #(.MASK(CSR_MASK[i]), .RSTV(CSR_RSTV[i])) u_csr (
      .clk(clk), .rst(rst),
      .we(bus_wr && (widx == IW'(CSR_WIDX[i]))),
      .be(bus_be), .wdata(bus_wdata), .q(csr_q[i]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_flush_q <= 1'b0;
      rx_flush_q <= 1'b0;
    end else begin
      tx_flush_q <= fctl_wr && bus_wdata[16] && bus_wdata[18];
      rx_flush_q <= fctl_wr && bus_wdata[16] && bus_wdata[17];
    end
  end

  urb_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst(rst), .flush(tx_flush_q),
    .push(bus_wr && (widx == IW'(WIDX_TXD)) && bus_be[0]),
    .din(bus_wdata[7:0]), .pop(tx_pop),
    .dout(tx_byte), .empty(tx_empty), .full(tx_full));

  urb_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .flush(rx_flush_q),
    .push(rx_valid), .din(rx_byte), .pop(rx_rd),
    .dout(rx_dout), .empty(rx_empty), .full(rx_full));

  assign tx_avail = !tx_empty;

  urb_flags u_flags (
    .clk(clk), .rst(rst),
    .clr_we(bus_wr && (widx == IW'(WIDX_FLAGS)) && bus_be[2]),
    .clr_keep(bus_wdata[18:16]),
    .rx_ne(!rx_empty), .tx_nf(!tx_full),
    .rie(csr_q[CI_ICTL][16]), .tie(csr_q[CI_ICTL][17]),
    .flags(flags), .irq(irq));

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NCSR; i++)
      if (widx == IW'(CSR_WIDX[i])) rd_mux = csr_q[i];
    if (widx == IW'(WIDX_FLAGS)) rd_mux = {13'b0, flags, 16'b0};
    if (widx == IW'(WIDX_RXD))   rd_mux = rx_empty ? 32'h0 : {24'h0, rx_dout};
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  AST_RX_EMPTY_READ: assert property (@(posedge clk) disable iff (rst)
    (rx_rd && rx_empty) |=> (bus_rdata == 32'h0)); // R7
  AST_RX_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
    (rx_full && rx_valid && !rx_rd && !rx_flush_q) |=> rx_full); // R7
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata)); // R11
endmodule

// File: tb/tb_uart_regblk.sv
`timescale 1ns/1ps
module tb_uart_regblk;
  localparam int DEPTH = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_wr = 0, bus_rd = 0, rx_valid = 0, tx_pop = 0;
  logic [7:0]  bus_addr = 0, rx_byte = 0;
  logic [3:0]  bus_be = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [7:0]  tx_byte;
  logic        tx_avail, irq;

  always #4 clk = ~clk;

  uart_regblk #(.FIFO_DEPTH(DEPTH), .ADDR_W(8)) dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_pop(tx_pop),
    .tx_byte(tx_byte), .tx_avail(tx_avail), .irq(irq));

  int nchk = 0, nerr = 0;
  bit done = 0, checking = 0;
  string dir_tag = "";

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [31:0] m_ctl [6];   // indexed by word offset 0..5 (3 unused)
  logic [2:0]  m_flags;
  logic [7:0]  txq[$], rxq[$];
  bit          m_txfl, m_rxfl, m_irq, m_rd_last;
  logic [31:0] m_rdata;
  string       m_rtag;

  function automatic logic [31:0] mask_of(input int w);
    case (w)
      0: return 32'hE17F0000;
      2: return 32'h000F0000;
      4: return 32'h001F0000;
      5: return 32'h03FF0000;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] bytes_in(input logic [31:0] o, input logic [31:0] n,
                                           input logic [3:0] be);
    logic [31:0] lm;
    lm = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    return (o & ~lm) | (n & lm);
  endfunction

  function automatic string tag_of(input int w);
    case (w)
      3: return "R8";
      12: return "R7";
      0, 2, 4, 5: return "R3";
      1: return "R4";
      default: return "R2";
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_ctl[0] = 32'h40000000; m_ctl[1] = 0; m_ctl[2] = 0; m_ctl[3] = 0;
      m_ctl[4] = 0; m_ctl[5] = 32'h03FF0000;
      m_flags = 0; txq.delete(); rxq.delete();
      m_txfl = 0; m_rxfl = 0; m_irq = 0; m_rd_last = 0; m_rdata = 0;
    end else begin
      automatic int w = int'(bus_addr[7:2]);
      automatic int rxn = rxq.size();
      automatic int txn = txq.size();
      automatic logic [2:0] keep = 3'b111;
      automatic bit irq_n = (m_flags[0] & m_ctl[2][16]) | (m_flags[1] & m_ctl[2][17]);
      automatic bit txfl_n, rxfl_n;
      if (bus_wr && w == 3 && bus_be[2]) keep = bus_wdata[18:16];
      m_rd_last = bus_rd;
      if (bus_rd) begin
        m_rtag = (dir_tag != "") ? dir_tag : tag_of(w);
        if (w <= 5 && w != 3) m_rdata = m_ctl[w];
        else if (w == 3) m_rdata = {13'b0, m_flags, 16'b0};
        else if (w == 12) m_rdata = (rxn > 0) ? {24'h0, rxq[0]} : 32'h0;
        else m_rdata = 0;
      end
      if (bus_rd && w == 12 && rxn > 0) void'(rxq.pop_front());
      if (rx_valid && rxn < DEPTH) rxq.push_back(rx_byte);
      if (m_rxfl) rxq.delete();
      if (tx_pop && txn > 0) void'(txq.pop_front());
      if (bus_wr && w == 8 && bus_be[0] && txn < DEPTH) txq.push_back(bus_wdata[7:0]);
      if (m_txfl) txq.delete();
      txfl_n = bus_wr && w == 4 && bus_be[2] && bus_wdata[16] && bus_wdata[18];
      rxfl_n = bus_wr && w == 4 && bus_be[2] && bus_wdata[16] && bus_wdata[17];
      m_txfl = txfl_n; m_rxfl = rxfl_n;
      if (bus_wr && w <= 5 && w != 3)
        m_ctl[w] = bytes_in(m_ctl[w], bus_wdata, bus_be) & mask_of(w);
      m_flags = (m_flags & keep) | {1'b0, txn < DEPTH, rxn > 0};
      m_irq = irq_n;
    end
  end

  always @(negedge clk) begin
    if (checking && !rst) begin
      if (m_rd_last) check(bus_rdata == m_rdata, m_rtag, bus_rdata, m_rdata);
      check(irq == m_irq, "R9", 32'(irq), 32'(m_irq));
      check(tx_avail == (txq.size() > 0), "R6", 32'(tx_avail), 32'(txq.size() > 0));
      if (tx_avail && txq.size() > 0) check(tx_byte == txq[0], "R6", 32'(tx_byte), 32'(txq[0]));
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle();
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; rx_valid = 0; tx_pop = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    bus_wr = 1; bus_rd = 0; bus_addr = a; bus_wdata = d; bus_be = be;
    rx_valid = 0; tx_pop = 0;
    idle();
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    @(negedge clk);
    dir_tag = tag;
    bus_rd = 1; bus_wr = 0; bus_addr = a; rx_valid = 0; tx_pop = 0;
    idle();
    dir_tag = "";
  endtask

  initial begin
    void'($urandom(32'd7193));
    repeat (3) @(negedge clk);
    rst = 0;
    checking = 1;
    // R1 reset values
    rd(8'd0, "R1"); rd(8'd20, "R1"); rd(8'd8, "R1"); rd(8'd16, "R1"); rd(8'd48, "R1");
    check(tx_avail == 0, "R1", 32'(tx_avail), 0);
    // R2 low address bits ignored, unmapped and transmit offsets read 0
    rd(8'd23, "R2"); rd(8'd24, "R2"); rd(8'd32, "R2");
    // R3 masks and lanes
    for (int w = 0; w < 6; w++) if (w != 3) wr(8'(w*4), 32'hFFFFFFFF, 4'hF);
    for (int w = 0; w < 6; w++) if (w != 3) rd(8'(w*4), "R3");
    wr(8'd0, 32'h0, 4'b0100); rd(8'd0, "R3");
    wr(8'd20, 32'h12345678, 4'b1000); rd(8'd20, "R3");
    // R4 line status stays zero
    wr(8'd4, 32'hFFFFFFFF, 4'hF); rd(8'd4, "R4");
    // R11 registered read timing
    rd(8'd20, "R11");
    wr(8'd16, 32'h0, 4'hF);
    // R5 fill transmit queue past depth
    for (int i = 0; i < DEPTH + 3; i++) wr(8'd32, 32'(8'hA0 + i), 4'h1);
    begin
      int popped = 0;
      while (tx_avail && popped < 20) begin
        @(negedge clk); tx_pop = 1; idle(); popped++;
      end
      check(popped == DEPTH, "R5", popped, DEPTH);
    end
    // R7 fill receive queue past depth, read out, then one read when empty
    for (int i = 0; i < DEPTH + 2; i++) begin
      @(negedge clk); rx_valid = 1; rx_byte = 8'(8'h50 + i); idle();
    end
    for (int i = 0; i < DEPTH + 1; i++) rd(8'd48, "R7");
    // R8 flag clear after condition gone, R9 irq enables
    wr(8'd8, 32'h00030000, 4'h4);
    repeat (2) idle();
    wr(8'd12, 32'h0, 4'h4); rd(8'd12, "R8");
    for (int i = 0; i < DEPTH; i++) wr(8'd32, 32'(i), 4'h1);
    repeat (2) idle();
    wr(8'd12, 32'h0, 4'h4); rd(8'd12, "R8");
    wr(8'd8, 32'h000C0000, 4'h4); repeat (3) idle();
    // R10 flush: without enable nothing, with enable transmit queue empties
    wr(8'd16, 32'h00040000, 4'h4); idle();
    check(tx_avail == 1, "R10", 32'(tx_avail), 1);
    wr(8'd16, 32'h00050000, 4'h4); idle();
    check(tx_avail == 0, "R10", 32'(tx_avail), 0);
    @(negedge clk); rx_valid = 1; rx_byte = 8'h3C; idle();
    wr(8'd16, 32'h00030000, 4'h4); rd(8'd48, "R10");
    // random phase
    for (int n = 0; n < 6000; n++) begin
      automatic int op = $urandom_range(0, 9);
      automatic int sel = $urandom_range(0, 9);
      automatic logic [7:0] a;
      @(negedge clk);
      case (sel)
        0: a = 8'd0;  1: a = 8'd8;  2: a = 8'd12; 3: a = 8'd16;
        4, 5: a = 8'd32; 6, 7: a = 8'd48; 8: a = 8'd20;
        default: a = 8'($urandom_range(0, 255));
      endcase
      bus_addr = a | 8'($urandom_range(0, 3));
      bus_wr = (op < 4); bus_rd = (op >= 4 && op < 7);
      bus_be = 4'($urandom_range(0, 15));
      bus_wdata = $urandom();
      if (a == 8'd16 && $urandom_range(0, 3) != 0) bus_wdata[18:16] = 3'b000;
      rx_valid = ($urandom_range(0, 2) == 0);
      rx_byte = 8'($urandom_range(0, 255));
      tx_pop = ($urandom_range(0, 2) == 0);
    end
    idle(); repeat (3) idle();
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule